// File: doc/BRIEF.md
# Reorder Buffer with Tag Wakeup

This block keeps the instructions that are in flight in a simple out-of-order core. Instructions are allocated into a circular buffer in program order. The index of the slot an instruction receives is its tag. Each source operand is stored either as a value that is already present or as the tag of the instruction that will produce it.

On every cycle the block offers one entry whose two sources are both present to a functional unit, choosing the oldest such entry. When a functional unit returns a tagged result, the block stores the result in the producing entry. In the same cycle it compares the tag against every waiting source, and each matching source captures the value.

Entries leave from the head in program order once their result has arrived. Each departure presents the destination register, the data and the tag. The surrounding logic uses the tag to decide whether the rename table still points at this producer.

Top module: `tag_rob`

## Requirements
- R1: After reset the buffer is empty. `iss_ready` is 1, `iss_tag` is 0, and both `ex_valid` and `cm_valid` are 0.
- R2: Issued instructions receive consecutive tags modulo DEPTH (default 8, so tag 7 is followed by tag 0). `iss_tag` always shows the tag that the next accepted issue will get.
- R3: With DEPTH entries outstanding, `iss_ready` is 0. An issue request in that state is ignored: no entry is allocated and `iss_tag` does not advance.
- R4: An entry is offered on the execute port only when both of its sources are present. While offered it drives its tag, opcode and both source values. An issue source with its ready flag at 0 carries a producer tag in its low TAG_W bits.
- R5: When several entries are ready, the entry offered is the oldest one counting from the head.
- R6: An entry is dispatched when `ex_valid` and `ex_ready` are both high, and it is never offered again after that.
- R7: A write-back places its data in the producing entry and marks that entry done. Any waiting source whose tag matches captures the data, and that entry can then be offered from the next cycle on.
- R8: If an issue source names a tag that is written back in the same cycle, the source is stored as present with the write-back data.
- R9: Commit happens only for the head entry, only after its write-back, and at most once per cycle. It presents `cm_tag`, `cm_dest` and `cm_data` and then frees the slot.
- R10: A younger entry that is done does not commit while an older entry at the head is still waiting for its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of issued instruction |
| iss_dest | input | REG_W | Destination register |
| iss_s1_rdy | input | 1 | Source 1 holds a value (1) or a tag (0) |
| iss_s1 | input | DATA_W | Source 1 value or producer tag |
| iss_s2_rdy | input | 1 | Source 2 holds a value (1) or a tag (0) |
| iss_s2 | input | DATA_W | Source 2 value or producer tag |
| iss_ready | output | 1 | A slot is free |
| iss_tag | output | TAG_W | Tag of the next allocated slot |
| ex_valid | output | 1 | A ready entry is offered |
| ex_ready | input | 1 | Functional unit accepts the offer |
| ex_tag | output | TAG_W | Tag of offered entry |
| ex_op | output | OP_W | Opcode of offered entry |
| ex_a | output | DATA_W | Source 1 value |
| ex_b | output | DATA_W | Source 2 value |
| wb_valid | input | 1 | Result returned |
| wb_tag | input | TAG_W | Tag of result producer |
| wb_data | input | DATA_W | Result value |
| cm_valid | output | 1 | Head entry commits this cycle |
| cm_tag | output | TAG_W | Tag of committing entry |
| cm_dest | output | REG_W | Destination register of committing entry |
| cm_data | output | DATA_W | Result of committing entry |

## Verification
The hardest case to reach from the ports is an issue whose source names a producer that is written back in the same clock edge. Without the issue-time capture, that source would wait forever on a broadcast that has already passed. The bench first issues the producer with the execute port held off. It then drives the dependent issue and the producer's write-back in one cycle, and releases the execute port. The dependent entry must then appear with the captured value.

Filling the buffer across the pointer wrap is also arranged deliberately. Write-backs are then returned out of order so that a done younger entry sits behind a waiting head.

// File: rtl/tag_rob.sv
module tag_rob #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [REG_W-1:0]  iss_dest,
  input  logic              iss_s1_rdy,
  input  logic [DATA_W-1:0] iss_s1,
  input  logic              iss_s2_rdy,
  input  logic [DATA_W-1:0] iss_s2,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              ex_valid,
  input  logic              ex_ready,
  output logic [TAG_W-1:0]  ex_tag,
  output logic [OP_W-1:0]   ex_op,
  output logic [DATA_W-1:0] ex_a,
  output logic [DATA_W-1:0] ex_b,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  output logic              cm_valid,
  output logic [TAG_W-1:0]  cm_tag,
  output logic [REG_W-1:0]  cm_dest,
  output logic [DATA_W-1:0] cm_data
);
  localparam int DEPTH = 1 << TAG_W;

  logic [DEPTH-1:0]  use_q, exec_q, pd_q, s1p_q, s2p_q;
  logic [OP_W-1:0]   op_q  [DEPTH];
  logic [REG_W-1:0]  dst_q [DEPTH];
  logic [DATA_W-1:0] s1_q  [DEPTH];
  logic [DATA_W-1:0] s2_q  [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [TAG_W:0]    hd_q, tl_q;

  logic [TAG_W-1:0] hd, tl, sel, k;
  logic             found;

  assign hd = hd_q[TAG_W-1:0];
  assign tl = tl_q[TAG_W-1:0];

  wire full   = (hd == tl) && (hd_q[TAG_W] != tl_q[TAG_W]);
  wire do_iss = iss_valid && !full;
  wire hit1   = !iss_s1_rdy && wb_valid && (iss_s1[TAG_W-1:0] == wb_tag);
  wire hit2   = !iss_s2_rdy && wb_valid && (iss_s2[TAG_W-1:0] == wb_tag);

  assign iss_ready = !full;
  assign iss_tag   = tl;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    k     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      k = hd + TAG_W'(i);
      if (!found && use_q[k] && !exec_q[k] && s1p_q[k] && s2p_q[k]) begin
        found = 1'b1;
        sel   = k;
      end
    end
  end

  assign ex_valid = found;
  assign ex_tag   = sel;
  assign ex_op    = op_q[sel];
  assign ex_a     = s1_q[sel];
  assign ex_b     = s2_q[sel];

  wire do_disp = found && ex_ready;

  assign cm_valid = use_q[hd] && pd_q[hd];
  assign cm_tag   = hd;
  assign cm_dest  = dst_q[hd];
  assign cm_data  = dat_q[hd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q  <= '0;
      exec_q <= '0;
      pd_q   <= '0;
      s1p_q  <= '0;
      s2p_q  <= '0;
      hd_q   <= '0;
      tl_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wb_valid && use_q[i]) begin
          if (TAG_W'(i) == wb_tag && !pd_q[i]) begin
            dat_q[i] <= wb_data;
            pd_q[i]  <= 1'b1;
          end
          if (!s1p_q[i] && s1_q[i][TAG_W-1:0] == wb_tag) begin
            s1_q[i]  <= wb_data;
            s1p_q[i] <= 1'b1;
          end
          if (!s2p_q[i] && s2_q[i][TAG_W-1:0] == wb_tag) begin
            s2_q[i]  <= wb_data;
            s2p_q[i] <= 1'b1;
          end
        end
      end
      if (do_disp) exec_q[sel] <= 1'b1;
      if (cm_valid) begin
        use_q[hd] <= 1'b0;
        hd_q      <= hd_q + 1'b1;
      end
      if (do_iss) begin
        use_q[tl]  <= 1'b1;
        exec_q[tl] <= 1'b0;
        pd_q[tl]   <= 1'b0;
        op_q[tl]   <= iss_op;
        dst_q[tl]  <= iss_dest;
        s1p_q[tl]  <= iss_s1_rdy || hit1;
        s2p_q[tl]  <= iss_s2_rdy || hit2;
        s1_q[tl]   <= hit1 ? wb_data : iss_s1;
        s2_q[tl]   <= hit2 ? wb_data : iss_s2;
        tl_q       <= tl_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tag_rob_chk.sv
module tag_rob_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [TAG_W-1:0] iss_tag,
  input logic             ex_valid,
  input logic             ex_ready,
  input logic [TAG_W-1:0] ex_tag,
  input logic             wb_valid,
  input logic [TAG_W-1:0] wb_tag,
  input logic             cm_valid,
  input logic [TAG_W-1:0] cm_tag
);
  localparam int DEPTH = 1 << TAG_W;

  int unsigned      cnt;
  logic [TAG_W-1:0] exp_tl, exp_hd;
  logic [DEPTH-1:0] disp, done;

  wire acc = iss_valid && iss_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= 0;
      exp_tl <= '0;
      exp_hd <= '0;
      disp   <= '0;
      done   <= '0;
    end else begin
      cnt <= cnt + (acc ? 1 : 0) - (cm_valid ? 1 : 0);
      if (ex_valid && ex_ready) disp[ex_tag] <= 1'b1;
      if (wb_valid) done[wb_tag] <= 1'b1;
      if (cm_valid) exp_hd <= exp_hd + 1'b1;
      if (acc) begin
        exp_tl       <= exp_tl + 1'b1;
        disp[exp_tl] <= 1'b0;
        done[exp_tl] <= 1'b0;
      end
    end
  end

  // R2
  tag_seq_chk: assert property (@(posedge clk) disable iff (!rst_n) iss_tag == exp_tl);
  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) (cnt == DEPTH) == !iss_ready);
  // R4
  offer_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n) ex_valid |-> cnt != 0);
  // R6
  single_disp_chk: assert property (@(posedge clk) disable iff (!rst_n) ex_valid |-> !disp[ex_tag]);
  // R9
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (cm_tag == exp_hd) && done[cm_tag]);
endmodule

bind tag_rob tag_rob_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_tag(iss_tag), .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_tag(ex_tag),
  .wb_valid(wb_valid), .wb_tag(wb_tag), .cm_valid(cm_valid), .cm_tag(cm_tag)
);

// File: tb/tag_rob_tb.sv
module tag_rob_tb;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_s1_rdy = 0, iss_s2_rdy = 0, ex_ready = 0, wb_valid = 0;
  logic [3:0]  iss_op = 0;
  logic [4:0]  iss_dest = 0;
  logic [15:0] iss_s1 = 0, iss_s2 = 0, wb_data = 0;
  logic [2:0]  wb_tag = 0;
  logic        iss_ready, ex_valid, cm_valid;
  logic [2:0]  iss_tag, ex_tag, cm_tag;
  logic [3:0]  ex_op;
  logic [4:0]  cm_dest;
  logic [15:0] ex_a, ex_b, cm_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tag_rob u_dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(input [3:0] op, input [4:0] d, input r1, input [15:0] v1,
                       input r2, input [15:0] v2);
    iss_valid = 1; iss_op = op; iss_dest = d;
    iss_s1_rdy = r1; iss_s1 = v1; iss_s2_rdy = r2; iss_s2 = v2;
    step();
    iss_valid = 0;
  endtask

  task automatic wback(input [2:0] t, input [15:0] d);
    wb_valid = 1; wb_tag = t; wb_data = d;
    step();
    wb_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 iss_tag", iss_tag, 0);
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 cm_valid", cm_valid, 0);
  endtask

  task automatic t_chain();
    issue(1, 3, 1, 10, 1, 20);
    chk("R2 tag after first", iss_tag, 1);
    issue(2, 4, 0, 0, 1, 5);
    chk("R2 tag after second", iss_tag, 2);
    chk("R4 offer valid", ex_valid, 1);
    chk("R4 offer tag", ex_tag, 0);
    chk("R4 offer op", ex_op, 1);
    chk("R4 offer a", ex_a, 10);
    chk("R4 offer b", ex_b, 20);
    ex_ready = 1; step(); ex_ready = 0;
    chk("R4 waiting entry not offered", ex_valid, 0);
    wback(0, 30);
    chk("R7 woken offered", ex_valid, 1);
    chk("R7 woken tag", ex_tag, 1);
    chk("R7 captured a", ex_a, 30);
    chk("R7 kept b", ex_b, 5);
    chk("R9 commit valid", cm_valid, 1);
    chk("R9 commit tag", cm_tag, 0);
    chk("R9 commit dest", cm_dest, 3);
    chk("R9 commit data", cm_data, 30);
    step();
    chk("R9 one commit", cm_valid, 0);
    ex_ready = 1; step(); ex_ready = 0;
    wback(1, 99);
    chk("R9 second commit tag", cm_tag, 1);
    chk("R9 second commit data", cm_data, 99);
    chk("R9 second commit dest", cm_dest, 4);
    step();
    chk("R9 drained", cm_valid, 0);
  endtask

  task automatic t_oldest();
    issue(5, 1, 1, 1, 1, 1);
    issue(6, 2, 1, 2, 1, 2);
    issue(7, 3, 1, 3, 1, 3);
    chk("R5 oldest tag", ex_tag, 2);
    chk("R5 oldest op", ex_op, 5);
    ex_ready = 1; step();
    chk("R5 next oldest", ex_tag, 3);
    step();
    chk("R5 youngest", ex_tag, 4);
    step(); ex_ready = 0;
    chk("R6 none offered again", ex_valid, 0);
    wback(4, 44);
    wback(3, 33);
    chk("R10 head blocks", cm_valid, 0);
    wback(2, 22);
    chk("R10 commit 2", cm_tag, 2);
    chk("R10 commit 2 valid", cm_valid, 1);
    step();
    chk("R10 commit 3", cm_tag, 3);
    chk("R10 commit 3 data", cm_data, 33);
    step();
    chk("R10 commit 4", cm_tag, 4);
    step();
    chk("R9 drained after order", cm_valid, 0);
  endtask

  task automatic t_full();
    int n = 0;
    for (int k = 0; k < 8; k++) begin
      issue(1, 5'(k), 1, 16'(k), 1, 0);
      if (k < 7) chk("R2 wrap tag", iss_tag, (5 + k + 1) % 8);
    end
    chk("R3 full stall", iss_ready, 0);
    issue(9, 9, 1, 7, 1, 7);
    chk("R3 ignored tag", iss_tag, 5);
    chk("R3 still full", iss_ready, 0);
    for (int k = 0; k < 8; k++) begin
      wback(3'((5 + k) % 8), 16'(100 + k));
      if (cm_valid) n++;
      chk("R9 commit order on wrap", cm_tag, (5 + k) % 8);
    end
    for (int k = 0; k < 4; k++) begin
      step();
      if (cm_valid) n++;
    end
    chk("R3 commit count", n, 8);
    chk("R3 tag after drain", iss_tag, 5);
    chk("R3 ready after drain", iss_ready, 1);
  endtask

  task automatic t_bypass();
    issue(3, 6, 1, 1, 1, 2);
    wb_valid = 1; wb_tag = 5; wb_data = 42;
    issue(4, 7, 0, 5, 1, 7);
    wb_valid = 0;
    chk("R8 producer offered first", ex_tag, 5);
    ex_ready = 1; step();
    chk("R8 dependent offered", ex_valid, 1);
    chk("R8 dependent tag", ex_tag, 6);
    chk("R8 captured value", ex_a, 42);
    chk("R8 other source", ex_b, 7);
    step(); ex_ready = 0;
    wback(6, 1);
    step();
    chk("R8 drained", cm_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_chain();
    t_oldest();
    t_full();
    t_bypass();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule